// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a bus-attached watchdog. A down-counter, clocked through a selectable prescaler, runs while the watchdog is enabled. If software fails to restart it in time, the counter expires and the block signals an overflow. The overflow can raise a level interrupt, issue a one-cycle internal reset request, and drive a fixed-length low pulse on an external pin. Each of these three actions has its own enable bit, and all of them sit under one master enable.

Both the mode register and the restart command are guarded by fixed keys. A stray write therefore cannot disable the watchdog or silence it.

The register bus is simple. It has a byte address, write data, a write strobe, a read strobe and combinational read data. The mode register is at 0x00, the clock mode register at 0x04, the control register at 0x08 and the status register at 0x0C.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the mode, clock mode and status registers read 0. After reset, irq_o and rst_req_o are 0 and ext_ovf_no is 1.
- R2: A write to offset 0x00 updates the mode register only when wdata_i[15:4] equals 0x234. With any other key value the register keeps its value.
- R3: Mode bit 0 is the master enable, bit 1 is the reset-request enable, bit 2 is the interrupt enable and bit 3 is the external-pulse enable. Bits 15:4 always read as 0.
- R4: The clock mode register at 0x04 is read/write and unkeyed. Bits 1:0 select the prescaler ratio: 0 gives /8, 1 gives /32, 2 gives /128 and 3 gives /1024. Bits 5:2 hold a 4-bit preload P.
- R5: After a valid restart, the first overflow occurs exactly N·(P+1)·2^ONES_W clock edges later, where N is the prescaler ratio. The counter is loaded with P followed by ONES_W one bits.
- R6: A write to offset 0x08 is a valid restart only when wdata_i[15:4] equals 0xA5C and wdata_i[0] is 1. A valid restart reloads the counter and clears the prescaler and the status bit. A write with any other key has no effect.
- R7: Status bit 0, at offset 0x0C, is set on overflow and stays set until a valid restart.
- R8: irq_o equals status bit 0 AND master enable AND interrupt enable.
- R9: rst_req_o is high for exactly the one cycle after an overflow, and only when the master enable and the reset-request enable are both set.
- R10: When the master enable and the external-pulse enable are set, ext_ovf_no is low for exactly 8 cycles, starting with the cycle after an overflow.
- R11: While the master enable is 0, the counter is held at its load value. No overflow occurs and no output asserts.
- R12: The control register reads 0. Misaligned offsets read 0, and writes to them change nothing. rdata_o is 0 whenever re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, valid while re_i is high |
| irq_o | output | 1 | Overflow interrupt level |
| rst_req_o | output | 1 | One-cycle internal reset request |
| ext_ovf_no | output | 1 | Active-low external overflow pulse |

## Verification
The timeout is measured edge by edge under every prescaler selection with a fixed preload. It is then measured under every preload value with the smallest ratio. This separates errors in the divider taps from errors in how the load value is formed. At each overflow the bench also checks the width of the reset-request pulse and of the external pulse, and whether the status bit is sticky. Mode writes with a key that differs from the correct one by one count, restarts with a wrong key, and accesses to misaligned offsets show that the locks hold. A run with the master enable cleared shows that a silent watchdog stays silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [11:0] MODE_KEY    = 12'h234;
  localparam logic [11:0] RESTART_KEY = 12'hA5C;
  localparam int OFF_MODE = 'h0;
  localparam int OFF_CLK  = 'h4;
  localparam int OFF_CTRL = 'h8;
  localparam int OFF_STAT = 'hC;
  localparam int PRE_W    = 10;

  function automatic int div_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3;
      2'd1:    return 5;
      2'd2:    return 7;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 ovf_i,
  output logic [3:0]           mode_o,
  output logic [1:0]           sel_o,
  output logic [PRELOAD_W-1:0] preload_o,
  output logic                 status_o,
  output logic                 restart_o
);
  localparam int CLK_W = 2 + PRELOAD_W;

  logic [3:0]       mode_q;
  logic [CLK_W-1:0] clk_q;
  logic             status_q;
  logic             hit_mode, hit_clk, hit_ctrl, hit_stat;

  assign hit_mode = addr_i == ADDR_W'(OFF_MODE);
  assign hit_clk  = addr_i == ADDR_W'(OFF_CLK);
  assign hit_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign hit_stat = addr_i == ADDR_W'(OFF_STAT);

  assign restart_o = we_i && hit_ctrl && wdata_i[15:4] == RESTART_KEY && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      clk_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (we_i && hit_mode && wdata_i[15:4] == MODE_KEY) mode_q <= wdata_i[3:0];
      if (we_i && hit_clk) clk_q <= wdata_i[CLK_W-1:0];
      if (restart_o)  status_q <= 1'b0;
      else if (ovf_i) status_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (hit_mode)      rdata_o[3:0]       = mode_q;
      else if (hit_clk)  rdata_o[CLK_W-1:0] = clk_q;
      else if (hit_stat) rdata_o[0]         = status_q;
    end
  end

  assign mode_o    = mode_q;
  assign sel_o     = clk_q[1:0];
  assign preload_o = clk_q[CLK_W-1:2];
  assign status_o  = status_q;

  assert_mode_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_mode && wdata_i[15:4] != MODE_KEY) |=> $stable(mode_q));
  assert_status_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !restart_o) |=> status_q);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler import wdt_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  always_comb last = PRE_W'((1 << div_shift(sel_i)) - 1);

  assign tick_o = en_i && !clr_i && cnt_q == last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || clr_i)    cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int PRELOAD_W = 4,
  parameter int ONES_W    = 12,
  parameter int PULSE_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rsten_i,
  input  logic                 exten_i,
  input  logic [PRELOAD_W-1:0] preload_i,
  input  logic                 tick_i,
  input  logic                 restart_i,
  output logic                 ovf_o,
  output logic                 rst_req_o,
  output logic                 ext_ovf_no
);
  localparam int CNT_W = PRELOAD_W + ONES_W;
  localparam int PL_W  = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, load;
  logic [PL_W-1:0]  pulse_q;
  logic             rst_req_q;

  assign load  = {preload_i, {ONES_W{1'b1}}};
  assign ovf_o = en_i && tick_i && !restart_i && cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pulse_q   <= '0;
      rst_req_q <= 1'b0;
    end else begin
      if (!en_i || restart_i) cnt_q <= load;
      else if (tick_i)        cnt_q <= (cnt_q == '0) ? load : cnt_q - 1'b1;

      rst_req_q <= ovf_o && rsten_i;

      if (!en_i)                  pulse_q <= '0;
      else if (ovf_o && exten_i)  pulse_q <= PL_W'(PULSE_LEN);
      else if (pulse_q != '0)     pulse_q <= pulse_q - 1'b1;
    end
  end

  assign rst_req_o  = rst_req_q;
  assign ext_ovf_no = pulse_q == '0;

  assert_rst_req_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_pulse_from_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_ovf_no) |-> $past(ovf_o));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 4,
  parameter int ONES_W    = 12,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              ext_ovf_no
);
  logic [3:0]           mode;
  logic [1:0]           sel;
  logic [PRELOAD_W-1:0] preload;
  logic                 status, restart, tick, ovf;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o,
    .ovf_i(ovf), .mode_o(mode), .sel_o(sel), .preload_o(preload),
    .status_o(status), .restart_o(restart)
  );

  wdt_prescaler u_pre (
    .clk_i, .rst_ni, .en_i(mode[0]), .clr_i(restart), .sel_i(sel), .tick_o(tick)
  );

  wdt_core #(.PRELOAD_W(PRELOAD_W), .ONES_W(ONES_W), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk_i, .rst_ni, .en_i(mode[0]), .rsten_i(mode[1]), .exten_i(mode[3]),
    .preload_i(preload), .tick_i(tick), .restart_i(restart),
    .ovf_o(ovf), .rst_req_o, .ext_ovf_no
  );

  assign irq_o = status && mode[0] && mode[2];
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  localparam int ONES_W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq, rst_req, ext_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_keyed #(.ONES_W(ONES_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req), .ext_ovf_no(ext_n)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic run_timeout(input int sel, input int p);
    logic [31:0] d;
    int k, low, expk;
    expk = (8 << (sel == 0 ? 0 : sel == 1 ? 2 : sel == 2 ? 4 : 7)) * (p + 1) * (1 << ONES_W);
    wr(4'h4, 32'((p << 2) | sel));
    rd(4'h4, d);
    check(d == 32'((p << 2) | sel), "R4 clock mode readback", d, (p << 2) | sel);
    wr(4'h8, 32'hA5C1);
    k = 0;
    do begin
      @(posedge clk); #1 k++;
    end while (!irq && k < expk + 10);
    check(k == expk, "R5 timeout edges", k, expk);
    check(rst_req == 1'b1, "R9 reset request on overflow", rst_req, 1);
    low = ext_n ? 0 : 1;
    @(posedge clk); #1;
    check(rst_req == 1'b0, "R9 reset request one cycle", rst_req, 0);
    while (!ext_n && low < 20) begin
      low++;
      @(posedge clk); #1;
    end
    check(low == 8, "R10 external pulse width", low, 8);
    rd(4'hC, d);
    check(d == 32'd1, "R7 status set", d, 1);
    wr(4'h8, 32'hA5D1);
    rd(4'hC, d);
    check(d == 32'd1, "R6 wrong restart key ignored", d, 1);
    wr(4'h8, 32'hA5C1);
    rd(4'hC, d);
    check(d == 32'd0, "R6 restart clears status", d, 0);
    check(irq == 1'b0, "R8 irq drops with status", irq, 0);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R0 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(irq == 0 && rst_req == 0 && ext_n == 1, "R1 outputs after reset",
          {irq, rst_req, ext_n}, 3'b001);
    rd(4'h0, d); check(d == 0, "R1 mode reset", d, 0);
    rd(4'h4, d); check(d == 0, "R1 clock mode reset", d, 0);
    rd(4'hC, d); check(d == 0, "R1 status reset", d, 0);

    wr(4'h0, 32'h0000_2335);
    rd(4'h0, d); check(d == 0, "R2 wrong key low", d, 0);
    wr(4'h0, 32'h0000_2355);
    rd(4'h0, d); check(d == 0, "R2 wrong key high", d, 0);
    wr(4'h0, 32'h0000_2345);
    rd(4'h0, d); check(d == 32'h5, "R3 key reads zero, bits kept", d, 5);
    wr(4'h1, 32'h0000_234F);
    rd(4'h0, d); check(d == 32'h5, "R12 misaligned write ignored", d, 5);
    rd(4'h1, d); check(d == 0, "R12 misaligned read", d, 0);
    rd(4'h8, d); check(d == 0, "R12 control reads zero", d, 0);
    @(negedge clk); addr = 4'h0; #1;
    check(rdata == 0, "R12 no read strobe", rdata, 0);

    // master enable off, all actions enabled
    wr(4'h0, 32'h0000_234E);
    wr(4'h4, 32'h0);
    wr(4'h8, 32'hA5C1);
    bad = 0;
    repeat (200) begin
      @(posedge clk); #1;
      if (irq || rst_req || !ext_n) bad++;
    end
    check(bad == 0, "R11 silent when disabled", bad, 0);
    rd(4'hC, d); check(d == 0, "R11 no overflow when disabled", d, 0);

    wr(4'h0, 32'h0000_234F);
    for (int s = 0; s < 4; s++) run_timeout(s, 1);
    for (int p = 0; p < 16; p++) run_timeout(0, p);

    // interrupt enable off while status set
    wr(4'h4, 32'h0);
    wr(4'h8, 32'hA5C1);
    wait (irq == 1'b1);
    @(negedge clk);
    wr(4'h0, 32'h0000_234B);
    #1 check(irq == 1'b0, "R8 irq gated by enable", irq, 0);
    rd(4'hC, d); check(d == 1, "R8 status still set", d, 1);
    wr(4'h0, 32'h0000_234F);
    #1 check(irq == 1'b1, "R8 irq returns with enable", irq, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule